// File: doc/BRIEF.md
# ADC Output Data Formatter

This block sits between a converter core and the digital output pads. On every clock it takes one offset-binary sample and an overflow flag. It registers one 13-bit output word: the overflow bit plus twelve data bits. Static mode bits from a control register choose how each sample is coded. Two's-complement coding flips the sample MSB. A scrambler XORs the upper data bits with the LSB. An odd-bit inversion mode flips every odd data bit; while it is on, the coding stays offset binary.

A three-bit pattern select replaces the sample path with a fixed or toggling test word for checking the board-level wiring. The pattern words also drive the overflow bit. An output-enable bit parks the whole interface. Data and overflow go low, the pad enable strobe drops so the pad ring can float the pins, and the gated data clock stops without a glitch.

The asynchronous active-low reset is synchronised inside the block before it reaches the registers.

Top module: `adc_out_fmt`

## Requirements
- R1: With all formatting off and pattern code 000, `data_o` and `ovf_o` equal the `sample_i` and `ovf_i` applied before the previous rising edge (one cycle of latency).
- R2: With `cfg_twos_i`=1, odd-bit inversion off and no pattern, `data_o` is the sample with bit 11 inverted and all other bits unchanged.
- R3: With `cfg_scramble_i`=1, data bits 11 down to 1 are each XORed with sample bit 0, and bit 0 is passed unchanged.
- R4: With `cfg_flip_odd_i`=1, data bits 1, 3, 5, 7, 9 and 11 are inverted, and `cfg_twos_i` has no effect on the output.
- R5: Scrambler and odd-bit inversion act together when both are on: the scrambled word then has its odd bits inverted.
- R6: Pattern code 001 forces `ovf_o` and all data bits to 1, and code 010 forces them all to 0. Both override two's-complement, scrambler and odd-bit inversion.
- R7: Pattern code 011 alternates: the first output after the code is selected is all ones on `{ovf_o,data_o}`, then all zeros, and so on each cycle.
- R8: Pattern code 100 produces a checkerboard. The first output after selection is `{ovf_o,data_o}`=13'h1555 (1 on the overflow bit, then alternating downwards). The next is 13'h0AAA, alternating each cycle.
- R9: A change of the pattern select to another toggling code restarts its phase at the first word. Codes 000, 101, 110 and 111 select the normal sample path.
- R10: With `cfg_oe_i`=0, after the next rising edge `data_o`, `ovf_o` and `pad_oe_o` are 0. From the second rising edge on, `dclk_o` stays low. With `cfg_oe_i`=1 held, `pad_oe_o` is 1 and `dclk_o` follows `clk`.
- R11: While `rst_n` is low, `data_o`, `ovf_o`, `pad_oe_o` and `dclk_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | DW | Offset-binary converter sample |
| ovf_i | input | 1 | Converter overflow flag |
| cfg_twos_i | input | 1 | Two's-complement coding select |
| cfg_scramble_i | input | 1 | Scrambler enable |
| cfg_flip_odd_i | input | 1 | Odd-bit inversion enable |
| cfg_pat_i | input | 3 | Test pattern select |
| cfg_oe_i | input | 1 | Output enable (1 = driving) |
| data_o | output | DW | Formatted data word |
| ovf_o | output | 1 | Formatted overflow bit |
| dclk_o | output | 1 | Gated data clock |
| pad_oe_o | output | 1 | Pad drive enable for the pad ring |

## Verification
The bench builds the block with the default width of twelve data bits. At this width the six inverted odd positions, the 13-bit checkerboard words 13'h1555 and 13'h0AAA and the bit-11 two's-complement flip can be checked against literal values. Samples with bit 0 set and clear show the scrambler both acting and passing through. Switching between the two toggling pattern codes, and to a reserved code, exercises the phase restart and the fall-back to the sample path.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  localparam int PAT_W = 3;
  localparam logic [PAT_W-1:0] PAT_NONE  = 3'b000;
  localparam logic [PAT_W-1:0] PAT_ONES  = 3'b001;
  localparam logic [PAT_W-1:0] PAT_ZEROS = 3'b010;
  localparam logic [PAT_W-1:0] PAT_ALT   = 3'b011;
  localparam logic [PAT_W-1:0] PAT_CHECK = 3'b100;
endpackage

// File: rtl/adc_fmt_code.sv
module adc_fmt_code #(
  parameter int DW = 12
) (
  input  logic [DW-1:0] sample_i,
  input  logic          twos_i,
  input  logic          scramble_i,
  input  logic          flip_odd_i,
  output logic [DW-1:0] coded_o
);
  logic [DW-1:0] odd_mask;
  logic [DW-1:0] step_twos;
  logic [DW-1:0] step_scr;

  for (genvar g = 0; g < DW; g++) begin : g_odd
    assign odd_mask[g] = ((g % 2) == 1);
  end

  // odd-bit inversion keeps offset binary, so it masks the MSB flip
  always_comb begin
    step_twos = sample_i;
    if (twos_i && !flip_odd_i) begin
      step_twos[DW-1] = ~sample_i[DW-1];
    end
  end

  always_comb begin
    step_scr = step_twos;
    if (scramble_i) begin
      step_scr[DW-1:1] = step_twos[DW-1:1] ^ {(DW-1){step_twos[0]}};
    end
  end

  always_comb begin
    coded_o = step_scr;
    if (flip_odd_i) begin
      coded_o = step_scr ^ odd_mask;
    end
  end
endmodule

// File: rtl/adc_fmt_pattern.sv
module adc_fmt_pattern
  import adc_fmt_pkg::*;
#(
  parameter int DW = 12,
  localparam int WW = DW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PAT_W-1:0] sel_i,
  output logic             active_o,
  output logic [WW-1:0]    word_o
);
  logic [PAT_W-1:0] sel_prev_q, sel_prev_d;
  logic             phase_q, phase_d;
  logic             phase_cur;
  logic             sel_changed;
  logic [WW-1:0]    chk_word;

  for (genvar g = 0; g < WW; g++) begin : g_chk
    assign chk_word[g] = (((DW - g) % 2) == 0);
  end

  always_comb begin
    sel_changed = (sel_i != sel_prev_q);
    phase_cur   = sel_changed ? 1'b0 : phase_q;
    phase_d     = ~phase_cur;
    sel_prev_d  = sel_i;
  end

  always_comb begin
    active_o = 1'b1;
    word_o   = '0;
    unique case (sel_i)
      PAT_ONES:  word_o = '1;
      PAT_ZEROS: word_o = '0;
      PAT_ALT:   word_o = phase_cur ? '0 : '1;
      PAT_CHECK: word_o = phase_cur ? ~chk_word : chk_word;
      default:   active_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev_q <= PAT_NONE;
      phase_q    <= 1'b0;
    end else begin
      sel_prev_q <= sel_prev_d;
      phase_q    <= phase_d;
    end
  end
endmodule

// File: rtl/adc_fmt_outreg.sv
module adc_fmt_outreg #(
  parameter int DW = 12,
  localparam int WW = DW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          oe_i,
  input  logic [WW-1:0] word_i,
  output logic [DW-1:0] data_o,
  output logic          ovf_o,
  output logic          pad_oe_o,
  output logic          dclk_o
);
  logic [WW-1:0] word_q, word_d;
  logic          oe_q, oe_d;
  logic          clk_en_q;

  always_comb begin
    word_d = oe_i ? word_i : '0;
    oe_d   = oe_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      word_q <= word_d;
      oe_q   <= oe_d;
    end
  end

  // enable captured while clk is low, so the gated clock never chops a pulse
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en_q <= 1'b0;
    end else begin
      clk_en_q <= oe_q;
    end
  end

  assign data_o   = word_q[DW-1:0];
  assign ovf_o    = word_q[DW];
  assign pad_oe_o = oe_q;
  assign dclk_o   = clk & clk_en_q;
endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt
  import adc_fmt_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    sample_i,
  input  logic             ovf_i,
  input  logic             cfg_twos_i,
  input  logic             cfg_scramble_i,
  input  logic             cfg_flip_odd_i,
  input  logic [PAT_W-1:0] cfg_pat_i,
  input  logic             cfg_oe_i,
  output logic [DW-1:0]    data_o,
  output logic             ovf_o,
  output logic             dclk_o,
  output logic             pad_oe_o
);
  localparam int WW = DW + 1;

  logic [1:0]    rst_sync_q;
  logic          rst_s_n;
  logic [DW-1:0] coded;
  logic          pat_active;
  logic [WW-1:0] pat_word;
  logic [WW-1:0] word_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_s_n = rst_sync_q[1];

  adc_fmt_code #(.DW(DW)) u_code (
    .sample_i   (sample_i),
    .twos_i     (cfg_twos_i),
    .scramble_i (cfg_scramble_i),
    .flip_odd_i (cfg_flip_odd_i),
    .coded_o    (coded)
  );

  adc_fmt_pattern #(.DW(DW)) u_pat (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .sel_i    (cfg_pat_i),
    .active_o (pat_active),
    .word_o   (pat_word)
  );

  // test patterns win over every coding option
  always_comb begin
    word_sel = pat_active ? pat_word : {ovf_i, coded};
  end

  adc_fmt_outreg #(.DW(DW)) u_out (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .oe_i     (cfg_oe_i),
    .word_i   (word_sel),
    .data_o   (data_o),
    .ovf_o    (ovf_o),
    .pad_oe_o (pad_oe_o),
    .dclk_o   (dclk_o)
  );
endmodule

// File: rtl/adc_out_fmt_chk.sv
module adc_out_fmt_chk
  import adc_fmt_pkg::*;
#(
  parameter int DW = 12
) (
  input logic             clk,
  input logic             rst_s_n,
  input logic [DW-1:0]    sample_i,
  input logic             ovf_i,
  input logic             cfg_twos_i,
  input logic             cfg_scramble_i,
  input logic             cfg_flip_odd_i,
  input logic [PAT_W-1:0] cfg_pat_i,
  input logic             cfg_oe_i,
  input logic [DW-1:0]    data_o,
  input logic             ovf_o,
  input logic             pad_oe_o
);
  logic up_q;
  logic [DW-1:0] odd_bits;

  for (genvar g = 0; g < DW; g++) begin : g_ob
    assign odd_bits[g] = ((g % 2) == 1);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) up_q <= 1'b0;
    else          up_q <= 1'b1;
  end

  AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_oe_i && cfg_pat_i == PAT_NONE && !cfg_twos_i && !cfg_scramble_i && !cfg_flip_odd_i)
    |=> (data_o == $past(sample_i) && ovf_o == $past(ovf_i))); // R1

  AST_TWOS_MSB: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_oe_i && cfg_pat_i == PAT_NONE && cfg_twos_i && !cfg_scramble_i && !cfg_flip_odd_i)
    |=> ((data_o ^ $past(sample_i)) == {1'b1, {(DW-1){1'b0}}})); // R2

  AST_ODD_FLIP: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_oe_i && cfg_pat_i == PAT_NONE && cfg_flip_odd_i && !cfg_scramble_i)
    |=> ((data_o ^ $past(sample_i)) == odd_bits)); // R4

  AST_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_oe_i && cfg_pat_i == PAT_ONES) |=> (&{ovf_o, data_o})); // R6

  AST_ALL_ZEROS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_oe_i && cfg_pat_i == PAT_ZEROS) |=> ({ovf_o, data_o} == '0)); // R6

  AST_ALT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (up_q && cfg_oe_i && $past(cfg_oe_i) && cfg_pat_i == PAT_ALT && $past(cfg_pat_i) == PAT_ALT)
    |=> ({ovf_o, data_o} == ~$past({ovf_o, data_o}))); // R7

  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!pad_oe_o) |-> (data_o == '0 && !ovf_o)); // R10

  AST_OE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_s_n)
    up_q |-> (pad_oe_o == $past(cfg_oe_i))); // R10
endmodule

bind adc_out_fmt adc_out_fmt_chk #(.DW(DW)) u_chk (
  .clk            (clk),
  .rst_s_n        (rst_s_n),
  .sample_i       (sample_i),
  .ovf_i          (ovf_i),
  .cfg_twos_i     (cfg_twos_i),
  .cfg_scramble_i (cfg_scramble_i),
  .cfg_flip_odd_i (cfg_flip_odd_i),
  .cfg_pat_i      (cfg_pat_i),
  .cfg_oe_i       (cfg_oe_i),
  .data_o         (data_o),
  .ovf_o          (ovf_o),
  .pad_oe_o       (pad_oe_o)
);

// File: tb/tb_adc_out_fmt.sv
module tb_adc_out_fmt;
  localparam int DW = 12;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] sample_i;
  logic          ovf_i;
  logic          cfg_twos_i, cfg_scramble_i, cfg_flip_odd_i, cfg_oe_i;
  logic [2:0]    cfg_pat_i;
  logic [DW-1:0] data_o;
  logic          ovf_o, dclk_o, pad_oe_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_out_fmt #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .ovf_i(ovf_i),
    .cfg_twos_i(cfg_twos_i), .cfg_scramble_i(cfg_scramble_i),
    .cfg_flip_odd_i(cfg_flip_odd_i), .cfg_pat_i(cfg_pat_i), .cfg_oe_i(cfg_oe_i),
    .data_o(data_o), .ovf_o(ovf_o), .dclk_o(dclk_o), .pad_oe_o(pad_oe_o)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_mode(input logic twos, input logic scr, input logic flip,
                          input logic [2:0] pat, input logic oe);
    cfg_twos_i = twos; cfg_scramble_i = scr; cfg_flip_odd_i = flip;
    cfg_pat_i = pat; cfg_oe_i = oe;
  endtask

  // drive at falling edge, sample just after the following rising edge
  task automatic step(input logic [DW-1:0] s, input logic ov);
    @(negedge clk);
    sample_i = s; ovf_i = ov;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [15:0] word13();
    return {3'b000, ovf_o, data_o};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    set_mode(0, 0, 0, 3'b000, 1);
    sample_i = 12'hABC; ovf_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset data/ovf", word13(), 16'h0000);
    check("R11 reset pad_oe/dclk", {14'd0, pad_oe_o, dclk_o}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_plain();
    set_mode(0, 0, 0, 3'b000, 1);
    step(12'h123, 1'b0); check("R1 plain 123", word13(), 16'h0123);
    step(12'hFFF, 1'b1); check("R1 plain FFF ovf", word13(), 16'h1FFF);
    check("R10 pad_oe high", {15'd0, pad_oe_o}, 16'h0001);
    check("R10 dclk follows clk", {15'd0, dclk_o}, 16'h0001);
  endtask

  task automatic t_twos();
    set_mode(1, 0, 0, 3'b000, 1);
    step(12'h123, 1'b0); check("R2 twos 123", word13(), 16'h0923);
    step(12'h801, 1'b1); check("R2 twos 801", word13(), 16'h1001);
  endtask

  task automatic t_scramble();
    set_mode(0, 1, 0, 3'b000, 1);
    step(12'h123, 1'b0); check("R3 scramble lsb1", word13(), 16'h0123 ^ 16'h0FFE);
    step(12'h7FE, 1'b0); check("R3 scramble lsb0", word13(), 16'h07FE);
  endtask

  task automatic t_flip();
    set_mode(1, 0, 1, 3'b000, 1);
    step(12'h123, 1'b0); check("R4 flip odd, twos ignored", word13(), 16'h0123 ^ 16'h0AAA);
    step(12'h000, 1'b1); check("R4 flip zero", word13(), 16'h1AAA);
  endtask

  task automatic t_both();
    set_mode(0, 1, 1, 3'b000, 1);
    step(12'h123, 1'b0); check("R5 scramble+flip", word13(), (16'h0123 ^ 16'h0FFE) ^ 16'h0AAA);
    step(12'h7FE, 1'b0); check("R5 scramble+flip lsb0", word13(), 16'h07FE ^ 16'h0AAA);
  endtask

  task automatic t_fixed();
    set_mode(1, 1, 1, 3'b001, 1);
    step(12'h123, 1'b0); check("R6 all ones", word13(), 16'h1FFF);
    set_mode(1, 1, 1, 3'b010, 1);
    step(12'hFFF, 1'b1); check("R6 all zeros", word13(), 16'h0000);
  endtask

  task automatic t_alt();
    set_mode(0, 0, 0, 3'b011, 1);
    step(12'h123, 1'b0); check("R7 alt first", word13(), 16'h1FFF);
    step(12'h123, 1'b0); check("R7 alt second", word13(), 16'h0000);
    step(12'h123, 1'b0); check("R7 alt third", word13(), 16'h1FFF);
  endtask

  task automatic t_check();
    set_mode(0, 0, 0, 3'b100, 1);
    step(12'h000, 1'b0); check("R8 checker first", word13(), 16'h1555);
    step(12'h000, 1'b0); check("R8 checker second", word13(), 16'h0AAA);
    step(12'h000, 1'b0); check("R8 checker third", word13(), 16'h1555);
  endtask

  task automatic t_reselect();
    set_mode(0, 0, 0, 3'b011, 1);
    step(12'h000, 1'b0); check("R9 alt start", word13(), 16'h1FFF);
    set_mode(0, 0, 0, 3'b100, 1);
    step(12'h000, 1'b0); check("R9 checker restart", word13(), 16'h1555);
    set_mode(0, 0, 0, 3'b011, 1);
    step(12'h000, 1'b0); check("R9 alt restart", word13(), 16'h1FFF);
    set_mode(0, 0, 0, 3'b101, 1);
    step(12'h456, 1'b1); check("R9 code 101 sample path", word13(), 16'h1456);
    set_mode(0, 0, 0, 3'b111, 1);
    step(12'h0F0, 1'b0); check("R9 code 111 sample path", word13(), 16'h00F0);
  endtask

  task automatic t_disable();
    set_mode(0, 0, 0, 3'b001, 0);
    step(12'hFFF, 1'b1);
    check("R10 disabled data", word13(), 16'h0000);
    check("R10 disabled pad_oe", {15'd0, pad_oe_o}, 16'h0000);
    step(12'hFFF, 1'b1);
    check("R10 dclk stopped", {15'd0, dclk_o}, 16'h0000);
    set_mode(0, 0, 0, 3'b000, 1);
    step(12'h321, 1'b0);
    step(12'h321, 1'b0);
    check("R10 re-enabled data", word13(), 16'h0321);
    check("R10 re-enabled dclk", {14'd0, pad_oe_o, dclk_o}, 16'h0003);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_plain();
    t_twos();
    t_scramble();
    t_flip();
    t_both();
    t_fixed();
    t_alt();
    t_check();
    t_reselect();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule